// File: doc/BRIEF.md
# Dual-Host Device Disable Register

This block holds a peripheral-disable control byte that two host interfaces can reach independently: a low-pin-count bus side (side A) and a serial management bus side (side B). Each side owns a private copy of the byte with its own write enable, read enable, write data and read data. A peripheral is disabled when either copy disables it, so both hosts must agree before a device is enabled.

Each copy carries a sticky lock bit. Once a side sets its lock, that copy ignores writes until the next power-on reset or host bus reset. The lock never affects the other copy. The block also produces the floppy write-protect indication. It ORs a software override bit with the external protect pin and with a forced-protect option gated by either drive select. It also gates the floppy controller's own activate bit with the merged floppy-disable bit.

Bit map of each copy: bit 0 write-protect override, bit 1 lock, bit 2 reserved (reads 0), bit 3 floppy disable, bit 4 serial port 1 disable, bit 5 serial port 2 disable, bit 6 parallel port disable, bit 7 reserved (reads 0).

Top module: `dual_host_disable_reg`

## Requirements
- R1: While por_n or bus_rst_n is low, both copies are cleared to 0x00, which clears every lock. The four disable outputs are also 0.
- R2: A write on a side whose lock (bit 1) is 0 loads that copy at the clock edge. Reading a copy returns its contents with bits 2 and 7 forced to 0.
- R3: While a copy's lock bit is 1, writes to that copy are ignored until a reset. This includes writes of 0 to bit 1, so the lock cannot be cleared by software.
- R4: A lock set in one copy has no effect on writes to the other copy.
- R5: Each disable output is the OR of its bit in both copies: dis_fdc bit 3, dis_ser1 bit 4, dis_ser2 bit 5, dis_par bit 6. The outputs are registered and change one clock after the copy changes.
- R6: fdc_active equals fdc_act_in AND NOT (bit 3 of either copy). It follows the copies combinationally.
- R7: wp_assert (1 = protected) is the OR of four terms: bit 0 of either copy, wp_pin, force_wp AND ds0, and force_wp AND ds1. It is combinational.
- R8: A side's read data is 0x00 whenever that side's read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst_n | input | 1 | Host bus reset, active low, asynchronous |
| a_we | input | 1 | Side A write enable |
| a_re | input | 1 | Side A read enable |
| a_wdata | input | 8 | Side A write data |
| a_rdata | output | 8 | Side A read data |
| b_we | input | 1 | Side B write enable |
| b_re | input | 1 | Side B read enable |
| b_wdata | input | 8 | Side B write data |
| b_rdata | output | 8 | Side B read data |
| fdc_act_in | input | 1 | Floppy controller activate bit |
| wp_pin | input | 1 | External write-protect pin, 1 = protected |
| force_wp | input | 1 | Forced-protect option bit |
| ds0 | input | 1 | Drive select 0 asserted |
| ds1 | input | 1 | Drive select 1 asserted |
| fdc_active | output | 1 | Floppy controller enabled |
| wp_assert | output | 1 | Write protect to the floppy controller, 1 = protected |
| dis_fdc | output | 1 | Floppy port disabled |
| dis_ser1 | output | 1 | Serial port 1 disabled |
| dis_ser2 | output | 1 | Serial port 2 disabled |
| dis_par | output | 1 | Parallel port disabled |

## Verification
Read data, fdc_active and wp_assert are due in the same cycle as the copy contents and pins that drive them. The copies take a write at the edge that ends the write cycle, and the disable outputs follow one edge after that. The bench model keeps a separate variable for the registered disable value, which it updates one step behind the copies. Inputs are driven after a falling edge and every output is compared a moment later, so each check sees the state left by the preceding rising edge.

// File: rtl/dual_host_disable_reg.sv
module dual_host_disable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         bus_rst_n,
  input  logic         a_we,
  input  logic         a_re,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  input  logic         b_we,
  input  logic         b_re,
  input  logic [W-1:0] b_wdata,
  output logic [W-1:0] b_rdata,
  input  logic         fdc_act_in,
  input  logic         wp_pin,
  input  logic         force_wp,
  input  logic         ds0,
  input  logic         ds1,
  output logic         fdc_active,
  output logic         wp_assert,
  output logic         dis_fdc,
  output logic         dis_ser1,
  output logic         dis_ser2,
  output logic         dis_par
);
  localparam logic [W-1:0] KEEP = W'(8'h7B);
  localparam int B_OVR = 0, B_LCK = 1, B_FDC = 3, B_S1 = 4, B_S2 = 5, B_PAR = 6;

  logic         rst;
  logic [W-1:0] cpy_a, cpy_b, both;
  logic [3:0]   dis_q;

  assign rst = ~por_n | ~bus_rst_n;

  always_ff @(posedge clk or posedge rst)
    if (rst)                      cpy_a <= '0;
    else if (a_we && !cpy_a[B_LCK]) cpy_a <= a_wdata & KEEP;

  always_ff @(posedge clk or posedge rst)
    if (rst)                      cpy_b <= '0;
    else if (b_we && !cpy_b[B_LCK]) cpy_b <= b_wdata & KEEP;

  assign both = cpy_a | cpy_b;

  always_ff @(posedge clk or posedge rst)
    if (rst) dis_q <= '0;
    else     dis_q <= {both[B_PAR], both[B_S2], both[B_S1], both[B_FDC]};

  assign {dis_par, dis_ser2, dis_ser1, dis_fdc} = dis_q;

  assign a_rdata    = a_re ? cpy_a : '0;
  assign b_rdata    = b_re ? cpy_b : '0;
  assign fdc_active = fdc_act_in & ~both[B_FDC];
  assign wp_assert  = both[B_OVR] | wp_pin | (force_wp & ds0) | (force_wp & ds1);

  AST_A_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    cpy_a[B_LCK] |=> $stable(a_rdata) || !a_re || !$past(a_re)); // R3
  AST_A_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cpy_a[B_LCK] |=> cpy_a[B_LCK]); // R3
  AST_B_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cpy_b[B_LCK] |=> cpy_b[B_LCK]); // R3
  AST_B_OPEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (b_we && !cpy_b[B_LCK]) |=> cpy_b == ($past(b_wdata) & KEEP)); // R4
  AST_DIS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dis_fdc == $past(cpy_a[B_FDC] | cpy_b[B_FDC])); // R5
  AST_RESV_ZERO: assert property (@(posedge clk)
    !a_rdata[2] && !a_rdata[7] && !b_rdata[2] && !b_rdata[7]); // R2
  AST_PIN_PROTECTS: assert property (@(posedge clk)
    wp_pin |-> wp_assert); // R7
  AST_NO_READ: assert property (@(posedge clk)
    !a_re |-> a_rdata == '0); // R8
endmodule

// File: tb/dual_host_disable_reg_tb.sv
module dual_host_disable_reg_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic por_n, bus_rst_n, a_we, a_re, b_we, b_re;
  logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic fdc_act_in, wp_pin, force_wp, ds0, ds1;
  logic fdc_active, wp_assert, dis_fdc, dis_ser1, dis_ser2, dis_par;

  dual_host_disable_reg u_dut (.*);

  int total = 0, bad = 0;
  int ma = 0, mb = 0, mdis = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int merged_dis(int x, int y);
    int m = x | y;
    return ((m >> 3) & 1) | (((m >> 4) & 1) << 1) | (((m >> 5) & 1) << 2) | (((m >> 6) & 1) << 3);
  endfunction

  task automatic check_all(string tag);
    int m = ma | mb;
    int wp = (m & 1) | wp_pin | (force_wp & ds0) | (force_wp & ds1);
    chk({tag, " R8/R2 a_rdata"}, a_rdata, a_re ? ma : 0);
    chk({tag, " R8/R2 b_rdata"}, b_rdata, b_re ? mb : 0);
    chk({tag, " R5 dis"}, {dis_par, dis_ser2, dis_ser1, dis_fdc}, mdis);
    chk({tag, " R6 fdc_active"}, fdc_active, fdc_act_in & !((m >> 3) & 1));
    chk({tag, " R7 wp_assert"}, wp_assert, wp);
  endtask

  task automatic cyc(string tag, bit wa, int da, bit wb, int db);
    a_we = wa; a_wdata = 8'(da); b_we = wb; b_wdata = 8'(db);
    a_re = 1; b_re = 1;
    #1 check_all(tag);
    mdis = merged_dis(ma, mb);
    if (wa && !(ma & 2)) ma = da & 8'h7B;
    if (wb && !(mb & 2)) mb = db & 8'h7B;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(bit use_por);
    if (use_por) por_n = 0; else bus_rst_n = 0;
    #1;
    ma = 0; mb = 0; mdis = 0;
    chk("R1 reset a_rdata", a_rdata, 0);
    chk("R1 reset dis", {dis_par, dis_ser2, dis_ser1, dis_fdc}, 0);
    @(posedge clk); @(negedge clk);
    por_n = 1; bus_rst_n = 1;
  endtask

  initial begin
    por_n = 0; bus_rst_n = 1; a_we = 0; b_we = 0; a_re = 1; b_re = 1;
    a_wdata = 0; b_wdata = 0; fdc_act_in = 1; wp_pin = 0; force_wp = 0; ds0 = 0; ds1 = 0;
    @(negedge clk);
    do_reset(1);
    cyc("R2 write a all", 1, 'hFF, 0, 0);
    cyc("R2 read", 0, 0, 0, 0);
    cyc("R5 lag", 0, 0, 0, 0);
    do_reset(0);
    cyc("R2 a ser1", 1, 'h10, 0, 0);
    cyc("R5 b par", 0, 0, 1, 'h40);
    cyc("R6 b fdc", 0, 0, 1, 'h48);
    cyc("R5 a clear", 1, 0, 0, 0);
    cyc("R5 settle", 0, 0, 0, 0);
    a_re = 0; b_re = 0; #1
    chk("R8 a idle", a_rdata, 0); chk("R8 b idle", b_rdata, 0);
    cyc("R3 lock a", 1, 'h22, 0, 0);
    cyc("R3 try clear", 1, 'h00, 0, 0);
    cyc("R3 try set", 1, 'h79, 0, 0);
    cyc("R4 b free", 0, 0, 1, 'h31);
    cyc("R4 b again", 0, 0, 1, 'h08);
    cyc("R4 lock b", 1, 'h01, 1, 'h02);
    cyc("R3 both locked", 1, 'h7B, 1, 'h7B);
    cyc("R3 hold", 0, 0, 0, 0);
    do_reset(0);
    cyc("R1 unlocked", 1, 'h08, 0, 0);
    cyc("R6 fdc off", 0, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin
      {wp_pin, force_wp, ds0, ds1, fdc_act_in} = 5'(i);
      cyc("R7 pins", i[0], (i == 7) ? 1 : 0, 0, 0);
    end
    cyc("R7 ovr b", 0, 0, 1, 'h01);
    wp_pin = 0; force_wp = 0;
    cyc("R7 ovr only", 0, 0, 0, 0);
    do_reset(1);
    cyc("R1 after por", 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin @(posedge clk); n++; end
    if (!done) begin total++; bad++; $display("FAIL watchdog act=0 exp=1"); end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule